// File: doc/BRIEF.md
# Debug Communications Data Channel

This block carries 32-bit words between a processor core and an external debug host, one word at a time in each direction. It has two one-deep mailboxes. The inbound mailbox is loaded by the debug host and drained by the core. The outbound mailbox is loaded by the core and drained by the debug host. Each mailbox has a full flag. Both flags are placed at fixed positions in a status word that a neighbouring status register decodes.

Each side drives single-cycle access strobes. A read strobe returns the word that the mailbox currently holds, on the same cycle, and marks the mailbox empty at the clock edge. A write strobe loads the word at the clock edge and marks the mailbox full. The two mailboxes treat a write into a full slot differently. The inbound slot drops the host write so that an unread word is never lost. The outbound slot accepts the new word from the core and reports the overwrite with a one-cycle pulse. Only the flags are reset. The stored words are kept through reset.

Top module: `dcc_channel`

## Requirements
- R1: After reset both full flags are 0, the status word is all zeros, and `tx_overrun` is 0.
- R2: A host write into an empty inbound mailbox sets `rx_full` at the next clock edge, and `core_rdata` then shows the written word.
- R3: A core read of the inbound mailbox returns the held word on the cycle of the strobe, and clears `rx_full` at the next edge (when no host write occurs in the same cycle).
- R4: A host write while `rx_full` is 1 and no core read occurs in the same cycle is ignored: the held word and the flag are unchanged.
- R5: A core write into the outbound mailbox sets `tx_full` at the next edge, and `ext_rdata` then shows the word.
- R6: A host read of the outbound mailbox returns the held word and clears `tx_full` at the next edge (when no core write occurs in the same cycle).
- R7: A core write while `tx_full` is 1 and no host read occurs in the same cycle replaces the word and keeps `tx_full` at 1. `tx_overrun` is 1 for exactly the one cycle after that edge.
- R8: Status bit 30 equals `rx_full` and status bit 29 equals `tx_full`. All other status bits are 0.
- R9: A core read of an empty inbound mailbox returns the last held word and leaves `rx_full` at 0.
- R10: When a core read and a host write reach a full inbound mailbox in the same cycle, the read returns the old word, the new word is stored, and `rx_full` stays 1.
- R11: When a host read and a core write reach a full outbound mailbox in the same cycle, the read returns the old word, the new word is stored, `tx_full` stays 1, and `tx_overrun` stays 0.
- R12: Reset clears the flags but leaves the held words visible on `core_rdata` and `ext_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| core_rd_rx | input | 1 | Core read strobe for the inbound mailbox |
| core_rdata | output | 32 | Word held in the inbound mailbox |
| core_wr_tx | input | 1 | Core write strobe for the outbound mailbox |
| core_wdata | input | 32 | Word written by the core |
| ext_wr_rx | input | 1 | Host write strobe for the inbound mailbox |
| ext_wdata | input | 32 | Word written by the host |
| ext_rd_tx | input | 1 | Host read strobe for the outbound mailbox |
| ext_rdata | output | 32 | Word held in the outbound mailbox |
| rx_full | output | 1 | Inbound mailbox holds an unread word |
| tx_full | output | 1 | Outbound mailbox holds an unread word |
| tx_overrun | output | 1 | One-cycle pulse after a core write overwrote an unread outbound word |
| status_bits | output | 32 | Flags packed at bits 30 (inbound) and 29 (outbound) |

## Verification
The bench targets the cycles in which both sides touch the same full mailbox. A design that treats a same-cycle read as a plain read would lose the new word or clear the flag under it. A design that ignores the full state would overwrite an unread inbound word, and a design that ignores the read would raise a false overrun. It also checks that a write into a full inbound slot keeps the old word, and that a read of an empty slot returns the stale word without changing the flag. It checks that the overrun pulse lasts exactly one cycle. Finally, it applies a reset while both words are held, to show that the data survives and only the flags drop.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   // What a mailbox does with a write that arrives while it is full
   typedef enum logic {
      FULL_DROP      = 1'b0,   // keep the unread word, ignore the write
      FULL_OVERWRITE = 1'b1    // take the new word, flag an overrun
   } full_policy_e;
endpackage

// File: rtl/dcc_slot.sv
module dcc_slot #(
   parameter int                    DATA_W = 32,
   parameter dcc_pkg::full_policy_e POLICY = dcc_pkg::FULL_DROP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              put,
   input  logic [DATA_W-1:0] put_data,
   input  logic              take,
   output logic [DATA_W-1:0] held,
   output logic              full,
   output logic              overrun
);
   logic accept;

   if (DATA_W < 1) begin : g_bad_width
      $error("dcc_slot: DATA_W must be at least 1");
   end

   if (POLICY == dcc_pkg::FULL_DROP) begin : g_drop
      // A same-cycle take frees the slot, so the put may land
      assign accept  = put & (~full | take);
      assign overrun = 1'b0;

      p_drop_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
         put && full && !take |=> full && $stable(held));
      p_pass_through_r10: assert property (@(posedge clk) disable iff (!rst_n)
         put && full && take |=> full && held == $past(put_data));
   end else begin : g_overwrite
      logic ovr_q;
      assign accept  = put;
      assign overrun = ovr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ovr_q <= 1'b0;
         else        ovr_q <= put & full & ~take;
      end

      p_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
         put && full && !take |=> full && overrun && held == $past(put_data));
      p_no_false_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !(put && full && !take) |=> !overrun);
   end

   // Flag: a write wins over a read landing in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      full <= 1'b0;
      else if (accept) full <= 1'b1;
      else if (take)   full <= 1'b0;
   end

   // Data word carries no reset
   always_ff @(posedge clk) begin
      if (accept) held <= put_data;
   end

   p_put_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
      put && (!full || take) |=> full && held == $past(put_data));
   p_take_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take && !put |=> !full);  // also R6 on the outbound slot
   p_flag_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !put && !take |=> $stable(full) && $stable(held));
endmodule

// File: rtl/dcc_status_map.sv
module dcc_status_map #(
   parameter int STATUS_W = 32,
   parameter int RX_POS   = 30,
   parameter int TX_POS   = 29
) (
   input  logic                rx_flag,
   input  logic                tx_flag,
   output logic [STATUS_W-1:0] status
);
   if (RX_POS >= STATUS_W || TX_POS >= STATUS_W || RX_POS < 0 || TX_POS < 0) begin : g_bad_pos
      $error("dcc_status_map: flag position outside the status word");
   end
   if (RX_POS == TX_POS) begin : g_same_pos
      $error("dcc_status_map: flag positions must differ");
   end

   always_comb begin
      status         = '0;
      status[RX_POS] = rx_flag;
      status[TX_POS] = tx_flag;
   end

   always_comb begin
      a_status_count_r8: assert ($countones(status) == 32'(rx_flag) + 32'(tx_flag));
   end
endmodule

// File: rtl/dcc_channel.sv
module dcc_channel #(
   parameter int DATA_W   = 32,
   parameter int STATUS_W = 32,
   parameter int RX_POS   = 30,
   parameter int TX_POS   = 29
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                core_rd_rx,
   output logic [DATA_W-1:0]   core_rdata,
   input  logic                core_wr_tx,
   input  logic [DATA_W-1:0]   core_wdata,
   input  logic                ext_wr_rx,
   input  logic [DATA_W-1:0]   ext_wdata,
   input  logic                ext_rd_tx,
   output logic [DATA_W-1:0]   ext_rdata,
   output logic                rx_full,
   output logic                tx_full,
   output logic                tx_overrun,
   output logic [STATUS_W-1:0] status_bits
);
   logic rx_ovr_unused;

   // Inbound: host -> core, unread word is protected
   dcc_slot #(.DATA_W(DATA_W), .POLICY(dcc_pkg::FULL_DROP)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .put     (ext_wr_rx),
      .put_data(ext_wdata),
      .take    (core_rd_rx),
      .held    (core_rdata),
      .full    (rx_full),
      .overrun (rx_ovr_unused)
   );

   // Outbound: core -> host, newest word wins
   dcc_slot #(.DATA_W(DATA_W), .POLICY(dcc_pkg::FULL_OVERWRITE)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .put     (core_wr_tx),
      .put_data(core_wdata),
      .take    (ext_rd_tx),
      .held    (ext_rdata),
      .full    (tx_full),
      .overrun (tx_overrun)
   );

   dcc_status_map #(.STATUS_W(STATUS_W), .RX_POS(RX_POS), .TX_POS(TX_POS)) u_map (
      .rx_flag(rx_full),
      .tx_flag(tx_full),
      .status (status_bits)
   );

   p_rx_never_overruns_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ovr_unused);
   p_overrun_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_overrun |=> !tx_overrun || $past(core_wr_tx));
endmodule

// File: tb/sim_dcc_channel.sv
module sim_dcc_channel;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        core_rd_rx, core_wr_tx, ext_wr_rx, ext_rd_tx;
   logic [31:0] core_wdata, ext_wdata;
   logic [31:0] core_rdata, ext_rdata, status_bits;
   logic        rx_full, tx_full, tx_overrun;
   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;   // 125 MHz

   dcc_channel u0 (
      .clk(clk), .rst_n(rst_n),
      .core_rd_rx(core_rd_rx), .core_rdata(core_rdata),
      .core_wr_tx(core_wr_tx), .core_wdata(core_wdata),
      .ext_wr_rx(ext_wr_rx), .ext_wdata(ext_wdata),
      .ext_rd_tx(ext_rd_tx), .ext_rdata(ext_rdata),
      .rx_full(rx_full), .tx_full(tx_full), .tx_overrun(tx_overrun),
      .status_bits(status_bits)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      core_rd_rx = 0; core_wr_tx = 0; ext_wr_rx = 0; ext_rd_tx = 0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic host_put(input logic [31:0] w);
      ext_wr_rx = 1; ext_wdata = w; step();
   endtask

   task automatic core_put(input logic [31:0] w);
      core_wr_tx = 1; core_wdata = w; step();
   endtask

   task automatic t_reset();
      rst_n = 0; idle(); core_wdata = '0; ext_wdata = '0;
      step(); step();
      chk("R1 rx_full", 32'(rx_full), 0);
      chk("R1 tx_full", 32'(tx_full), 0);
      chk("R1 status", status_bits, 0);
      chk("R1 overrun", 32'(tx_overrun), 0);
      rst_n = 1; step();
   endtask

   task automatic t_rx_basic();
      host_put(32'hA5A5_0001);
      chk("R2 rx_full", 32'(rx_full), 1);
      chk("R2 rdata", core_rdata, 32'hA5A5_0001);
      chk("R8 rx bit", status_bits, 32'h4000_0000);
      core_rd_rx = 1;
      chk("R3 read value", core_rdata, 32'hA5A5_0001);
      step();
      chk("R3 rx cleared", 32'(rx_full), 0);
      chk("R8 empty status", status_bits, 0);
   endtask

   task automatic t_rx_drop();
      host_put(32'h1111_2222);
      host_put(32'h3333_4444);
      chk("R4 flag kept", 32'(rx_full), 1);
      chk("R4 word kept", core_rdata, 32'h1111_2222);
      core_rd_rx = 1; step();
   endtask

   task automatic t_rx_empty_read();
      core_rd_rx = 1;
      chk("R9 stale value", core_rdata, 32'h1111_2222);
      step();
      chk("R9 flag stays 0", 32'(rx_full), 0);
      chk("R9 word kept", core_rdata, 32'h1111_2222);
   endtask

   task automatic t_rx_same_cycle();
      host_put(32'hC0C0_0C0C);
      core_rd_rx = 1; ext_wr_rx = 1; ext_wdata = 32'hD0D0_0D0D;
      chk("R10 old word read", core_rdata, 32'hC0C0_0C0C);
      step();
      chk("R10 flag stays", 32'(rx_full), 1);
      chk("R10 new word", core_rdata, 32'hD0D0_0D0D);
      core_rd_rx = 1; step();
   endtask

   task automatic t_tx_basic();
      core_put(32'hEEEE_0005);
      chk("R5 tx_full", 32'(tx_full), 1);
      chk("R5 rdata", ext_rdata, 32'hEEEE_0005);
      chk("R8 tx bit", status_bits, 32'h2000_0000);
      chk("R5 no overrun", 32'(tx_overrun), 0);
      ext_rd_tx = 1;
      chk("R6 read value", ext_rdata, 32'hEEEE_0005);
      step();
      chk("R6 tx cleared", 32'(tx_full), 0);
   endtask

   task automatic t_tx_overrun();
      core_put(32'hF000_000F);
      chk("R7 no pulse first", 32'(tx_overrun), 0);
      core_put(32'h6000_0006);
      chk("R7 flag stays", 32'(tx_full), 1);
      chk("R7 word replaced", ext_rdata, 32'h6000_0006);
      chk("R7 pulse", 32'(tx_overrun), 1);
      step();
      chk("R7 pulse one cycle", 32'(tx_overrun), 0);
      ext_rd_tx = 1; step();
   endtask

   task automatic t_tx_same_cycle();
      core_put(32'h7777_0007);
      core_wr_tx = 1; core_wdata = 32'h8888_0008; ext_rd_tx = 1;
      chk("R11 old word read", ext_rdata, 32'h7777_0007);
      step();
      chk("R11 flag stays", 32'(tx_full), 1);
      chk("R11 new word", ext_rdata, 32'h8888_0008);
      chk("R11 no overrun", 32'(tx_overrun), 0);
      ext_rd_tx = 1; step();
   endtask

   task automatic t_both_and_reset();
      ext_wr_rx = 1; ext_wdata = 32'h0BAD_F00D;
      core_wr_tx = 1; core_wdata = 32'h0C0F_FEE0;
      step();
      chk("R8 both bits", status_bits, 32'h6000_0000);
      rst_n = 0; step(); step();
      chk("R1 rx_full after reset", 32'(rx_full), 0);
      chk("R1 tx_full after reset", 32'(tx_full), 0);
      chk("R12 rx word kept", core_rdata, 32'h0BAD_F00D);
      chk("R12 tx word kept", ext_rdata, 32'h0C0F_FEE0);
      rst_n = 1; step();
   endtask

   initial begin
      t_reset();
      t_rx_basic();
      t_rx_drop();
      t_rx_empty_read();
      t_rx_same_cycle();
      t_tx_basic();
      t_tx_overrun();
      t_tx_same_cycle();
      t_both_and_reset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule